// File: doc/BRIEF.md
# Pre-Bias Synchronous Rectifier Ramp Sequencer

This block drives the high-side and low-side gate enables of a synchronous buck power stage for each switching period, and it protects a pre-charged output during start-up. A period begins on a one-cycle strobe. The block latches the commanded high-side on-time in clock ticks and clamps it between a minimum pulse and a maximum duty limit. It drives the high-side gate, waits a dead band, drives the low-side gate, and then waits a second dead band before the period ends.

When the output already holds charge, a full-width synchronous rectifier would pull current back out of the load. The sequencer therefore withholds all switching until the soft-start reference has risen above the feedback level, a condition reported by the analog front end as a flag. Once switching is released, the low-side on-time starts at a narrow initial width. It widens by a fixed step at every period until it fills the whole complementary interval, and it then stays at full width. A new soft-start (a rising edge on the soft-start-active flag) stops switching and re-arms this protection. The comparator and the PWM ramp that produces the on-time are outside this block.

Top module: `sr_prebias_seq`

## Requirements
- R1: While reset is high, and in the cycle after reset, both gate enables are low, and the ramp is not released.
- R2: Until `ref_above_fb` is seen high on a cycle where `period_start` is high, every period has both gates low. The period whose strobe sees that flag high is the first switching period.
- R3: In a switching period, `hs_gate` is high for the first T cycles after the strobe cycle. T = clamp(`hs_on_ticks`, MIN_ON, PERIOD*MAX_DUTY_PCT/100), using integer division.
- R4: After the high-side pulse, `ls_gate` stays low for DEAD cycles before it rises. The low-side pulse ends no later than cycle PERIOD-DEAD of the period, counting the first high-side cycle as cycle 0.
- R5: In the first switching period after release, the low-side width is min(LS_INIT, F), where F = PERIOD - 2*DEAD - T.
- R6: In each later period, the stored width grows by LS_STEP and saturates at PERIOD - 2*DEAD. The low-side width used is min(stored, F).
- R7: On a rising edge of `ss_active`, both gates are low from the next cycle. The ramp returns to the unreleased state, so the next release starts again at LS_INIT.
- R8: `hs_gate` and `ls_gate` are never high in the same cycle.
- R9: If no new strobe arrives after PERIOD cycles, both gates stay low until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle strobe that starts a switching period |
| hs_on_ticks | input | TICK_W | Commanded high-side on-time in clock ticks |
| ref_above_fb | input | 1 | Soft-start reference is above the feedback level |
| ss_active | input | 1 | Soft-start in progress; a rising edge marks a new start-up |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side (synchronous rectifier) gate enable |

## Verification
The dead-band properties assume that strobes are at least PERIOD cycles apart. An earlier strobe would cut the trailing dead band before the next high-side pulse. The stimulus therefore always spaces strobes by PERIOD plus zero to a few idle cycles, and it sometimes omits a strobe to exercise the idle tail. `hs_on_ticks` and `ref_above_fb` are assumed to be sampled only at the strobe. The stimulus changes them freely between strobes, and the soft-start pulses are placed at arbitrary cycles within a period.

// File: rtl/sr_prebias_pkg.sv
package sr_prebias_pkg;

    typedef int unsigned uint_t;

    typedef enum logic [2:0] {
        PH_HIGH,
        PH_GAP_A,
        PH_LOW,
        PH_GAP_B,
        PH_IDLE
    } phase_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gates_t;

    function automatic uint_t min_u(input uint_t a, input uint_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic uint_t clamp_u(input uint_t v, input uint_t lo, input uint_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/sr_period_timer.sv
module sr_period_timer
    import sr_prebias_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [TICK_W-1:0] cnt
);
    localparam uint_t LAST = uint_t'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TICK_W'(LAST);
        end else if (start) begin
            cnt <= '0;
        end else if (uint_t'(cnt) < LAST) begin
            cnt <= cnt + TICK_W'(1);
        end
    end

endmodule

// File: rtl/sr_ramp_ctrl.sv
module sr_ramp_ctrl
    import sr_prebias_pkg::*;
#(
    parameter int PERIOD       = 40,
    parameter int DEAD         = 2,
    parameter int MIN_ON       = 4,
    parameter int MAX_DUTY_PCT = 90,
    parameter int LS_INIT      = 3,
    parameter int LS_STEP      = 4,
    parameter int TICK_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TICK_W-1:0] hs_cmd,
    input  logic              ref_above_fb,
    input  logic              ss_active,
    output logic              run,
    output logic [TICK_W-1:0] ton,
    output logic [TICK_W-1:0] ls_width
);
    localparam uint_t MAX_ON = uint_t'(PERIOD * MAX_DUTY_PCT / 100);
    localparam uint_t LS_CAP = uint_t'(PERIOD - 2 * DEAD);

    logic              ss_q;
    logic              rel_q;
    logic              run_q;
    logic [TICK_W-1:0] ton_q;
    logic [TICK_W-1:0] lsw_q;
    logic              ss_rise;
    uint_t             ton_next;
    uint_t             lsw_grow;

    assign ss_rise = ss_active & ~ss_q;

    always_comb begin
        ton_next = clamp_u(uint_t'(hs_cmd), uint_t'(MIN_ON), MAX_ON);
        lsw_grow = min_u(uint_t'(lsw_q) + uint_t'(LS_STEP), LS_CAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_q  <= 1'b0;
            rel_q <= 1'b0;
            run_q <= 1'b0;
            ton_q <= TICK_W'(MIN_ON);
            lsw_q <= '0;
        end else begin
            ss_q <= ss_active;
            if (ss_rise) begin
                rel_q <= 1'b0;
                run_q <= 1'b0;
                lsw_q <= '0;
            end else if (start) begin
                ton_q <= TICK_W'(ton_next);
                if (rel_q) begin
                    run_q <= 1'b1;
                    lsw_q <= TICK_W'(lsw_grow);
                end else if (ref_above_fb) begin
                    rel_q <= 1'b1;
                    run_q <= 1'b1;
                    lsw_q <= TICK_W'(min_u(uint_t'(LS_INIT), LS_CAP));
                end else begin
                    run_q <= 1'b0;
                end
            end
        end
    end

    assign run      = run_q;
    assign ton      = ton_q;
    assign ls_width = TICK_W'(min_u(uint_t'(lsw_q), LS_CAP - uint_t'(ton_q)));

endmodule

// File: rtl/sr_gate_decode.sv
module sr_gate_decode
    import sr_prebias_pkg::*;
#(
    parameter int DEAD   = 2,
    parameter int TICK_W = 8
) (
    input  logic [TICK_W-1:0] cnt,
    input  logic              run,
    input  logic [TICK_W-1:0] ton,
    input  logic [TICK_W-1:0] ls_width,
    output gates_t            gates
);
    phase_e phase;
    uint_t  c;
    uint_t  hs_end;
    uint_t  gap_end;
    uint_t  ls_end;

    always_comb begin
        c       = uint_t'(cnt);
        hs_end  = uint_t'(ton);
        gap_end = hs_end + uint_t'(DEAD);
        ls_end  = gap_end + uint_t'(ls_width);
        if (!run)              phase = PH_IDLE;
        else if (c < hs_end)   phase = PH_HIGH;
        else if (c < gap_end)  phase = PH_GAP_A;
        else if (c < ls_end)   phase = PH_LOW;
        else                   phase = PH_GAP_B;
        gates.hs = (phase == PH_HIGH);
        gates.ls = (phase == PH_LOW);
    end

endmodule

// File: rtl/sr_prebias_seq.sv
module sr_prebias_seq
    import sr_prebias_pkg::*;
#(
    parameter int PERIOD       = 40,
    parameter int DEAD         = 2,
    parameter int MIN_ON       = 4,
    parameter int MAX_DUTY_PCT = 90,
    parameter int LS_INIT      = 3,
    parameter int LS_STEP      = 4,
    parameter int TICK_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_start,
    input  logic [TICK_W-1:0] hs_on_ticks,
    input  logic              ref_above_fb,
    input  logic              ss_active,
    output logic              hs_gate,
    output logic              ls_gate
);
    logic [TICK_W-1:0] cnt;
    logic              run;
    logic [TICK_W-1:0] ton;
    logic [TICK_W-1:0] ls_width;
    gates_t            gates;

    sr_period_timer #(
        .PERIOD (PERIOD),
        .TICK_W (TICK_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (period_start),
        .cnt   (cnt)
    );

    sr_ramp_ctrl #(
        .PERIOD       (PERIOD),
        .DEAD         (DEAD),
        .MIN_ON       (MIN_ON),
        .MAX_DUTY_PCT (MAX_DUTY_PCT),
        .LS_INIT      (LS_INIT),
        .LS_STEP      (LS_STEP),
        .TICK_W       (TICK_W)
    ) u_ramp (
        .clk          (clk),
        .rst          (rst),
        .start        (period_start),
        .hs_cmd       (hs_on_ticks),
        .ref_above_fb (ref_above_fb),
        .ss_active    (ss_active),
        .run          (run),
        .ton          (ton),
        .ls_width     (ls_width)
    );

    sr_gate_decode #(
        .DEAD   (DEAD),
        .TICK_W (TICK_W)
    ) u_decode (
        .cnt      (cnt),
        .run      (run),
        .ton      (ton),
        .ls_width (ls_width),
        .gates    (gates)
    );

    assign hs_gate = gates.hs;
    assign ls_gate = gates.ls;

endmodule

// File: rtl/sr_prebias_seq_chk.sv
module sr_prebias_seq_chk #(
    parameter int MAX_ON = 36
) (
    input logic clk,
    input logic rst,
    input logic period_start,
    input logic ref_above_fb,
    input logic ss_active,
    input logic hs_gate,
    input logic ls_gate
);
    logic        c_ss_q;
    logic        c_rel;
    logic [15:0] hs_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_ss_q <= 1'b0;
            c_rel  <= 1'b0;
            hs_len <= '0;
        end else begin
            c_ss_q <= ss_active;
            if (ss_active && !c_ss_q)
                c_rel <= 1'b0;
            else if (period_start && ref_above_fb)
                c_rel <= 1'b1;
            if (hs_gate && hs_len != 16'hFFFF)
                hs_len <= hs_len + 16'd1;
            else if (!hs_gate)
                hs_len <= '0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!hs_gate && !ls_gate));

    p_withheld_r2: assert property (@(posedge clk) disable iff (rst)
        !c_rel |-> (!hs_gate && !ls_gate));

    p_hs_cap_r3: assert property (@(posedge clk) disable iff (rst)
        hs_gate |-> (hs_len < 16'(MAX_ON)));

    p_gap_after_hs_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_gate) |-> !ls_gate);

    p_gap_after_ls_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ls_gate) |-> !hs_gate);

    p_ss_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_active) |=> (!hs_gate && !ls_gate));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate));

endmodule

bind sr_prebias_seq sr_prebias_seq_chk #(
    .MAX_ON (PERIOD * MAX_DUTY_PCT / 100)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .period_start (period_start),
    .ref_above_fb (ref_above_fb),
    .ss_active    (ss_active),
    .hs_gate      (hs_gate),
    .ls_gate      (ls_gate)
);

// File: tb/sim_sr_prebias_seq.sv
`timescale 1ns/1ps
module sim_sr_prebias_seq;
    localparam int PERIOD       = 40;
    localparam int DEAD         = 2;
    localparam int MIN_ON       = 4;
    localparam int MAX_DUTY_PCT = 90;
    localparam int LS_INIT      = 3;
    localparam int LS_STEP      = 4;
    localparam int TICK_W       = 8;
    localparam int MAX_ON       = PERIOD * MAX_DUTY_PCT / 100;
    localparam int LS_CAP       = PERIOD - 2 * DEAD;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              period_start = 1'b0;
    logic [TICK_W-1:0] hs_on_ticks = '0;
    logic              ref_above_fb = 1'b0;
    logic              ss_active = 1'b0;
    logic              hs_gate;
    logic              ls_gate;

    int checks = 0;
    int failures = 0;

    // bench model state
    int m_cnt = PERIOD - 1;
    int m_ton = MIN_ON;
    int m_lsw = 0;
    bit m_run = 0;
    bit m_rel = 0;
    bit m_ssq = 0;
    bit m_first = 0;
    bit m_kill = 0;
    int m_since = 0;

    always #2.5 clk = ~clk;

    sr_prebias_seq #(
        .PERIOD (PERIOD), .DEAD (DEAD), .MIN_ON (MIN_ON),
        .MAX_DUTY_PCT (MAX_DUTY_PCT), .LS_INIT (LS_INIT),
        .LS_STEP (LS_STEP), .TICK_W (TICK_W)
    ) u0 (
        .clk (clk), .rst (rst), .period_start (period_start),
        .hs_on_ticks (hs_on_ticks), .ref_above_fb (ref_above_fb),
        .ss_active (ss_active), .hs_gate (hs_gate), .ls_gate (ls_gate)
    );

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int clamp_on(input int v);
        if (v < MIN_ON) return MIN_ON;
        if (v > MAX_ON) return MAX_ON;
        return v;
    endfunction

    function automatic bit [1:0] exp_gates();
        int eff;
        if (!m_run) return 2'b00;
        eff = imin(m_lsw, LS_CAP - m_ton);
        return {(m_cnt < m_ton),
                (m_cnt >= m_ton + DEAD) && (m_cnt < m_ton + DEAD + eff)};
    endfunction

    task automatic model_edge();
        bit rise;
        if (rst) begin
            m_cnt = PERIOD - 1; m_ton = MIN_ON; m_lsw = 0;
            m_run = 0; m_rel = 0; m_ssq = 0; m_first = 0; m_kill = 0;
            m_since = 0;
        end else begin
            rise  = ss_active && !m_ssq;
            m_ssq = ss_active;
            if (rise) begin
                m_rel = 0; m_run = 0; m_lsw = 0; m_kill = 1;
            end else if (period_start) begin
                m_ton  = clamp_on(int'(hs_on_ticks));
                m_kill = 0;
                if (m_rel) begin
                    m_run = 1; m_first = 0;
                    m_lsw = imin(m_lsw + LS_STEP, LS_CAP);
                end else if (ref_above_fb) begin
                    m_rel = 1; m_run = 1; m_first = 1;
                    m_lsw = imin(LS_INIT, LS_CAP);
                end else begin
                    m_run = 0;
                end
            end
            if (period_start) begin
                m_cnt = 0; m_since = 0;
            end else begin
                if (m_cnt < PERIOD - 1) m_cnt = m_cnt + 1;
                m_since = m_since + 1;
            end
        end
    endtask

    task automatic check(input string tag, input bit [1:0] act, input bit [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: gates {hs,ls} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit [1:0] e;
        bit [1:0] a;
        string tag;
        e = exp_gates();
        a = {hs_gate, ls_gate};
        if (rst || !m_rel && !m_kill && m_since == 0 && !m_run && m_cnt == PERIOD - 1 && checks < 4)
            tag = "R1";
        else if (m_kill)                   tag = "R7";
        else if (!m_run)                   tag = "R2";
        else if (m_since >= PERIOD)        tag = "R9";
        else if (m_cnt < m_ton)            tag = "R3";
        else if (m_cnt < m_ton + DEAD)     tag = "R4";
        else if (m_first)                  tag = "R5";
        else                               tag = "R6";
        check(tag, a, e);
        checks++;
        if (hs_gate && ls_gate) begin
            failures++;
            $display("FAIL R8: both gates high actual=11 expected=not 11 at %0t", $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    // one period: strobe, PERIOD-1 further cycles, then extra idle cycles
    task automatic period(input int cmd, input bit ref_hi, input int extra);
        period_start = 1'b1;
        hs_on_ticks  = TICK_W'(cmd);
        ref_above_fb = ref_hi;
        step();
        period_start = 1'b0;
        for (int i = 0; i < PERIOD - 1 + extra; i++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        step();
        check("R1", {hs_gate, ls_gate}, 2'b00);

        // R2: pre-biased start, reference below feedback: withheld
        ss_active = 1'b1;
        step();
        for (int p = 0; p < 3; p++) period(12, 1'b0, 0);

        // R5/R6: release, ramp from narrow to full width (F = 36-10 = 26)
        for (int p = 0; p < 10; p++) period(10, 1'b1, 0);
        ss_active = 1'b0;
        for (int p = 0; p < 2; p++) period(10, 1'b0, 0);

        // R3: clamp at both ends
        period(1, 1'b1, 0);
        period(0, 1'b1, 0);
        period(200, 1'b1, 0);
        period(MAX_ON, 1'b1, 0);

        // R9: missed strobe, idle tail
        period(20, 1'b1, 15);

        // R7: new soft-start in the middle of a period
        period_start = 1'b1; hs_on_ticks = 8'd8; ref_above_fb = 1'b1;
        step();
        period_start = 1'b0;
        for (int i = 0; i < 5; i++) step();
        ss_active = 1'b1;
        for (int i = 0; i < PERIOD - 6; i++) step();
        period(8, 1'b0, 0);
        period(8, 1'b1, 0);
        period(8, 1'b1, 0);

        // random mix
        for (int p = 0; p < 80; p++) begin
            int cmd;
            bit rh;
            int extra;
            cmd   = int'($urandom % 64);
            rh    = (($urandom % 4) != 0);
            extra = int'($urandom % 4);
            if (($urandom % 12) == 0) ss_active = 1'b0;
            else if (($urandom % 12) == 0) ss_active = 1'b1;
            period(cmd, rh, extra);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule